// File: doc/BRIEF.md
# Multi-Latency Issue Interlock

This block decides, every cycle, whether the instruction held in the decode stage of an in-order pipeline may enter execution or must wait. Behind it sit five kinds of operation with different latencies: a single-cycle integer operation, a two-cycle load, a pipelined six-cycle floating multiply, a pipelined three-cycle floating add and a non-pipelined divide that completes after 28 cycles and occupies its unit for 28 cycles. All of them retire through a single register write slot, one result per cycle.

The block keeps three pieces of state. The first is a ring of booked completion cycles. The second is a per-register countdown to the cycle in which a pending result becomes usable. The third is an occupancy counter for the divider. From this state it detects four conditions: a source still waiting on a producer (read-after-write), a destination that an older, slower operation would overwrite later (write-after-write), a completion cycle that is already taken, and a busy divider. When any of them holds, one stall signal is raised and nothing is recorded for the held instruction. Write-after-read needs no check, because operands are read when execution starts and issue is in order.

Timing convention: an instruction issued in cycle t with latency L produces its result at the end of cycle t+L. A consumer issued in cycle c may use that result through forwarding when c >= t+L.

Top module: `fp_issue_interlock`

## Requirements
- R1: After reset, every booking, countdown and divider occupancy is cleared, so the first valid instruction issues whatever its unit, sources and destination.
- R2: When id_valid is 0, issue_go and issue_stall are both 0. When id_valid is 1, exactly one of them is 1.
- R3: A source with its enable set, naming a register whose producer was issued in cycle t with latency L, stalls in every cycle c < t+L and passes from c = t+L onward. An integer result is therefore used back-to-back, a load result one cycle later, and a multiply result six cycles later. This holds on both source ports.
- R4: An instruction that writes register r stalls when an earlier, still-pending write to r would complete after its own completion cycle.
- R5: An instruction that writes a register stalls when its completion cycle t+L is already booked by an issued instruction. The divider's completion counts as a booking, so a pipelined unit cannot complete in the same cycle as the divider.
- R6: A divide issued in cycle t blocks any further divide until cycle t+28. The divide presented in cycle t+28 may issue.
- R7: A stalled instruction books no completion cycle, starts no countdown and does not occupy the divider.
- R8: An instruction with id_dst_en = 0 books no completion cycle and is never stalled by the write-slot or write-after-write checks.
- R9: A source whose enable bit is 0 is never checked, whatever that register's countdown holds.
- R10: id_unit encodes the unit as follows: 0 integer (latency 1), 1 load (latency 2), 2 multiply (latency 6), 3 add (latency 3), 4 divide (latency 28). Codes 5, 6 and 7 are handled as integer operations.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| id_valid | input | 1 | An instruction is present in decode |
| id_unit | input | 3 | Unit code of the instruction (see R10) |
| id_src_a | input | REG_AW (5) | First source register number |
| id_src_a_en | input | 1 | First source is read |
| id_src_b | input | REG_AW (5) | Second source register number |
| id_src_b_en | input | 1 | Second source is read |
| id_dst | input | REG_AW (5) | Destination register number |
| id_dst_en | input | 1 | Instruction writes a register |
| issue_go | output | 1 | Instruction leaves decode at the coming edge |
| issue_stall | output | 1 | Instruction is held in decode |

## Verification
The hardest situation to reach from the ports is a pipelined operation that collides with the divider's write-back. That collision can only occur more than twenty cycles after the divide was accepted, and it is easily hidden behind the divider's own busy stall. The stimulus therefore issues a divide and keeps offering a second divide each cycle to watch the occupancy window close exactly on cycle 28. In the one cycle where a multiply would complete together with the divider, it offers that multiply instead. The write-after-write stall and the write-slot stall are also kept apart: the stimulus picks destinations and spacings so that only one of the two conditions can hold in the cycle being checked.

// File: rtl/fpil_pkg.sv
package fpil_pkg;

  // unit codes presented on id_unit
  localparam logic [2:0] UNIT_INT  = 3'd0;
  localparam logic [2:0] UNIT_LOAD = 3'd1;
  localparam logic [2:0] UNIT_FMUL = 3'd2;
  localparam logic [2:0] UNIT_FADD = 3'd3;
  localparam logic [2:0] UNIT_FDIV = 3'd4;

  function automatic int max_of2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fpil_slot_ring.sv
// Ring of booked completion cycles. Bit j set: some result completes
// j+1 cycles after the current one.
module fpil_slot_ring #(
  parameter int DEPTH = 28,
  parameter int LAT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LAT_W-1:0] lat_in,
  input  logic             book,
  output logic             conflict
);

  logic [DEPTH-1:0] booked_q;
  logic [DEPTH-1:0] booked_d;
  logic [DEPTH-1:0] probe;

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    // the offset the candidate would occupy in this cycle
    assign probe[j] = (lat_in == LAT_W'(j + 1));
    // after the edge, everything moves one step closer; a new booking
    // lands one step below its latency
    if (j == DEPTH - 1) begin : g_top
      assign booked_d[j] = book && (lat_in == LAT_W'(j + 2));
    end else begin : g_mid
      assign booked_d[j] = booked_q[j+1] | (book && (lat_in == LAT_W'(j + 2)));
    end
  end

  assign conflict = |(booked_q & probe);

  always_ff @(posedge clk) begin
    if (rst) begin
      booked_q <= '0;
    end else begin
      booked_q <= booked_d;
    end
  end

endmodule

// File: rtl/fpil_pend_table.sv
// Per-register countdown: cycles left until a pending result can be
// forwarded. Zero means the register is free to read and to overwrite.
module fpil_pend_table #(
  parameter int REG_AW = 5,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] rd_a,
  input  logic [REG_AW-1:0] rd_b,
  input  logic [REG_AW-1:0] rd_d,
  input  logic              wr_en,
  input  logic [CNT_W-1:0]  wr_val,
  output logic [CNT_W-1:0]  cnt_a,
  output logic [CNT_W-1:0]  cnt_b,
  output logic [CNT_W-1:0]  cnt_d
);

  localparam int NREG = 1 << REG_AW;

  logic [CNT_W-1:0] left_q [NREG];

  assign cnt_a = left_q[rd_a];
  assign cnt_b = left_q[rd_b];
  assign cnt_d = left_q[rd_d];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < NREG; r++) begin
        left_q[r] <= '0;
      end
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (wr_en && (rd_d == REG_AW'(r))) begin
          left_q[r] <= wr_val;
        end else if (left_q[r] != '0) begin
          left_q[r] <= left_q[r] - CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/fpil_div_gate.sv
// Occupancy of the iterative divider after it accepts an operation.
module fpil_div_gate #(
  parameter int II = 28
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);

  localparam int CW = $clog2(II);

  logic [CW-1:0] left_q;

  assign busy = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (start) begin
      left_q <= CW'(II - 1);
    end else if (busy) begin
      left_q <= left_q - CW'(1);
    end
  end

endmodule

// File: rtl/fp_issue_interlock.sv
module fp_issue_interlock
  import fpil_pkg::*;
#(
  parameter int REG_AW   = 5,
  parameter int INT_LAT  = 1,
  parameter int LOAD_LAT = 2,
  parameter int FMUL_LAT = 6,
  parameter int FADD_LAT = 3,
  parameter int FDIV_LAT = 28,
  parameter int FDIV_II  = 28
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              id_valid,
  input  logic [2:0]        id_unit,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic              id_src_a_en,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_src_b_en,
  input  logic [REG_AW-1:0] id_dst,
  input  logic              id_dst_en,
  output logic              issue_go,
  output logic              issue_stall
);

  localparam int MAX_LAT = max_of2(max_of2(max_of2(INT_LAT, LOAD_LAT),
                                           max_of2(FMUL_LAT, FADD_LAT)), FDIV_LAT);
  localparam int LAT_W   = $clog2(MAX_LAT + 1);

  logic [LAT_W-1:0] lat;
  logic             is_div;
  logic [LAT_W-1:0] cnt_a, cnt_b, cnt_d;
  logic             slot_taken;
  logic             div_busy;
  logic             raw_hit, waw_hit, slot_hit, busy_hit, blocked;
  logic             commit, div_start;

  // latency of the decoded unit; unknown codes behave as integer
  always_comb begin
    case (id_unit)
      UNIT_LOAD: lat = LAT_W'(LOAD_LAT);
      UNIT_FMUL: lat = LAT_W'(FMUL_LAT);
      UNIT_FADD: lat = LAT_W'(FADD_LAT);
      UNIT_FDIV: lat = LAT_W'(FDIV_LAT);
      default:   lat = LAT_W'(INT_LAT);
    endcase
  end

  assign is_div = (id_unit == UNIT_FDIV);

  fpil_slot_ring #(
    .DEPTH (MAX_LAT),
    .LAT_W (LAT_W)
  ) u_slot_ring (
    .clk      (clk),
    .rst      (rst),
    .lat_in   (lat),
    .book     (commit),
    .conflict (slot_taken)
  );

  fpil_pend_table #(
    .REG_AW (REG_AW),
    .CNT_W  (LAT_W)
  ) u_pend_table (
    .clk    (clk),
    .rst    (rst),
    .rd_a   (id_src_a),
    .rd_b   (id_src_b),
    .rd_d   (id_dst),
    .wr_en  (commit),
    .wr_val (lat - LAT_W'(1)),
    .cnt_a  (cnt_a),
    .cnt_b  (cnt_b),
    .cnt_d  (cnt_d)
  );

  fpil_div_gate #(
    .II (FDIV_II)
  ) u_div_gate (
    .clk   (clk),
    .rst   (rst),
    .start (div_start),
    .busy  (div_busy)
  );

  // hazard terms
  assign raw_hit  = (id_src_a_en && (cnt_a != '0)) || (id_src_b_en && (cnt_b != '0));
  assign waw_hit  = id_dst_en && (cnt_d > lat);
  assign slot_hit = id_dst_en && slot_taken;
  assign busy_hit = is_div && div_busy;
  assign blocked  = raw_hit | waw_hit | slot_hit | busy_hit;

  assign issue_go    = id_valid & ~blocked;
  assign issue_stall = id_valid &  blocked;

  // only an issuing instruction leaves a trace in the state
  assign commit    = issue_go & id_dst_en;
  assign div_start = issue_go & is_div;

endmodule

// File: rtl/fpil_checker.sv
module fpil_checker
  import fpil_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              id_valid,
  input logic [2:0]        id_unit,
  input logic [REG_AW-1:0] id_src_a,
  input logic              id_src_a_en,
  input logic [REG_AW-1:0] id_src_b,
  input logic              id_src_b_en,
  input logic [REG_AW-1:0] id_dst,
  input logic              id_dst_en,
  input logic              issue_go,
  input logic              issue_stall
);

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    !(issue_go && issue_stall));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !id_valid |-> (!issue_go && !issue_stall));

  assert_clean_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && id_valid) |-> issue_go);

  assert_load_use_a_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_go && id_dst_en && id_unit == UNIT_LOAD)
      |=> !(issue_go && id_src_a_en && id_src_a == $past(id_dst)));

  assert_load_use_b_R3: assert property (@(posedge clk) disable iff (rst)
    (issue_go && id_dst_en && id_unit == UNIT_LOAD)
      |=> !(issue_go && id_src_b_en && id_src_b == $past(id_dst)));

  assert_no_early_overwrite_R4: assert property (@(posedge clk) disable iff (rst)
    (issue_go && id_dst_en && id_unit == UNIT_FMUL)
      |=> !(issue_go && id_dst_en && id_unit == UNIT_INT && id_dst == $past(id_dst)));

  assert_single_write_slot_R5: assert property (@(posedge clk) disable iff (rst)
    (issue_go && id_dst_en && id_unit == UNIT_LOAD)
      |=> !(issue_go && id_dst_en && id_unit == UNIT_INT));

  assert_divider_occupied_R6: assert property (@(posedge clk) disable iff (rst)
    (issue_go && id_unit == UNIT_FDIV) |=> !(issue_go && id_unit == UNIT_FDIV));

endmodule

bind fp_issue_interlock fpil_checker #(.REG_AW(REG_AW)) u_fpil_checker (.*);

// File: tb/test_fp_issue_interlock.sv
module test_fp_issue_interlock;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;

  typedef struct packed {
    logic       v;
    logic [2:0] u;
    logic [4:0] d;
    logic       w;
    logic [4:0] a;
    logic       ae;
    logic [4:0] b;
    logic       be;
    logic       go;
    logic [3:0] req;
  } vec_t;

  // one entry per cycle, starting with the first cycle after reset;
  // units: 0 int(1) 1 load(2) 2 mul(6) 3 add(3) 4 div(28)
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 3'd0, 5'd0,  1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd2},  // c0  idle, R2
    '{1'b1, 3'd0, 5'd1,  1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 4'd1},  // c1  first after reset, R1
    '{1'b1, 3'd0, 5'd2,  1'b1, 5'd1,  1'b1, 5'd0,  1'b0, 1'b1, 4'd3},  // c2  int result back-to-back, R3
    '{1'b1, 3'd1, 5'd3,  1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 4'd3},  // c3  load r3
    '{1'b1, 3'd0, 5'd0,  1'b0, 5'd3,  1'b1, 5'd0,  1'b0, 1'b0, 4'd3},  // c4  load-use stall, R3
    '{1'b1, 3'd0, 5'd0,  1'b0, 5'd3,  1'b1, 5'd0,  1'b0, 1'b1, 4'd3},  // c5  load-use released, R3
    '{1'b1, 3'd2, 5'd5,  1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 4'd3},  // c6  mul r5, done c12
    '{1'b1, 3'd3, 5'd6,  1'b1, 5'd5,  1'b1, 5'd0,  1'b0, 1'b0, 4'd3},  // c7  add reads r5, R3
    '{1'b1, 3'd3, 5'd5,  1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd4},  // c8  add writes r5 early, R4
    '{1'b1, 3'd0, 5'd7,  1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 4'd7},  // c9  c10 free (c7 booked none), R7
    '{1'b1, 3'd0, 5'd8,  1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 4'd7},  // c10 c11 free (c8 booked none), R7
    '{1'b1, 3'd0, 5'd9,  1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd5},  // c11 c12 taken by mul, R5
    '{1'b1, 3'd3, 5'd6,  1'b1, 5'd5,  1'b1, 5'd0,  1'b0, 1'b1, 4'd3},  // c12 mul result usable, R3
    '{1'b1, 3'd1, 5'd10, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd5},  // c13 c15 taken by add, R5
    '{1'b1, 3'd0, 5'd0,  1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 4'd8},  // c14 no write, c15 ignored, R8
    '{1'b1, 3'd4, 5'd11, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 4'd6},  // c15 divide r11, done c43
    '{1'b1, 3'd4, 5'd12, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd6},  // c16 divider busy, R6
    '{1'b1, 3'd2, 5'd11, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd4},  // c17 mul overwrites r11 early, R4
    '{1'b1, 3'd2, 5'd15, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 4'd5},  // c18 mul r15, done c24
    '{1'b0, 3'd0, 5'd0,  1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd2},  // c19 idle, R2
    '{1'b1, 3'd0, 5'd0,  1'b0, 5'd15, 1'b0, 5'd0,  1'b0, 1'b1, 4'd9},  // c20 disabled source, R9
    '{1'b1, 3'd0, 5'd0,  1'b0, 5'd0,  1'b0, 5'd15, 1'b1, 1'b0, 4'd3},  // c21 second port RAW, R3
    '{1'b0, 3'd0, 5'd0,  1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd2},  // c22 idle, R2
    '{1'b1, 3'd5, 5'd16, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 4'd10}, // c23 code 5 as int hits c24, R10
    '{1'b1, 3'd6, 5'd16, 1'b1, 5'd0,  1'b0, 5'd15, 1'b1, 1'b1, 4'd10}  // c24 code 6 as int, R10
  };

  logic       clk = 1'b0;
  logic       rst;
  logic       id_valid;
  logic [2:0] id_unit;
  logic [4:0] id_src_a, id_src_b, id_dst;
  logic       id_src_a_en, id_src_b_en, id_dst_en;
  logic       issue_go, issue_stall;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  fp_issue_interlock i_fp_issue_interlock (
    .clk         (clk),
    .rst         (rst),
    .id_valid    (id_valid),
    .id_unit     (id_unit),
    .id_src_a    (id_src_a),
    .id_src_a_en (id_src_a_en),
    .id_src_b    (id_src_b),
    .id_src_b_en (id_src_b_en),
    .id_dst      (id_dst),
    .id_dst_en   (id_dst_en),
    .issue_go    (issue_go),
    .issue_stall (issue_stall)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic present(input logic v, input logic [2:0] u, input logic [4:0] d,
                         input logic w, input logic [4:0] a, input logic ae,
                         input logic [4:0] b, input logic be);
    id_valid    = v;
    id_unit     = u;
    id_dst      = d;
    id_dst_en   = w;
    id_src_a    = a;
    id_src_a_en = ae;
    id_src_b    = b;
    id_src_b_en = be;
  endtask

  task automatic expect_out(input logic exp_go, input string tag);
    logic exp_stall;
    exp_stall = id_valid & ~exp_go;
    checks++;
    if (issue_go !== exp_go || issue_stall !== exp_stall) begin
      errors++;
      $display("FAIL %s: go/stall actual=%b%b expected=%b%b",
               tag, issue_go, issue_stall, exp_go, exp_stall);
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    present(0, 0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 expect_out(1'b0, "R2 idle during reset");
    rst = 1'b0;

    // table walk: one vector per cycle
    for (int i = 0; i < NVEC; i++) begin
      present(VEC[i].v, VEC[i].u, VEC[i].d, VEC[i].w,
              VEC[i].a, VEC[i].ae, VEC[i].b, VEC[i].be);
      #1 expect_out(VEC[i].go, $sformatf("R%0d vector c%0d", VEC[i].req, i));
      @(negedge clk);
    end

    // divider occupancy window (divide issued c15) and divider write-back slot c43
    for (int c = NVEC; c < 43; c++) begin
      if (c == 37) begin
        present(1, 3'd2, 5'd20, 1, 0, 0, 0, 0);  // mul would complete with the divide, R5
        #1 expect_out(1'b0, "R5 mul against divider write-back c37");
      end else begin
        present(1, 3'd4, 5'd12, 1, 0, 0, 0, 0);
        #1 expect_out(1'b0, $sformatf("R6 divide while busy c%0d", c));
      end
      @(negedge clk);
    end
    present(1, 3'd4, 5'd12, 1, 0, 0, 0, 0);
    #1 expect_out(1'b1, "R6 divide accepted at 28 cycles c43");
    @(negedge clk);
    present(1, 3'd4, 5'd22, 1, 0, 0, 0, 0);
    #1 expect_out(1'b0, "R6 divide right after divide c44");
    @(negedge clk);

    // reset with divider busy and r12 pending
    rst = 1'b1;
    present(0, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    #1 expect_out(1'b0, "R2 idle in reset");
    rst = 1'b0;
    present(1, 3'd4, 5'd21, 1, 5'd12, 1, 0, 0);
    #1 expect_out(1'b1, "R1 divide reading r12 after reset");
    @(negedge clk);
    present(1, 3'd0, 5'd23, 1, 5'd21, 1, 0, 0);
    #1 expect_out(1'b0, "R3 int reading pending divide result");
    @(negedge clk);
    present(1, 3'd0, 5'd23, 1, 5'd21, 0, 5'd21, 0);
    #1 expect_out(1'b1, "R9 both sources disabled");
    @(negedge clk);
    present(0, 0, 0, 0, 0, 0, 0, 0);
    #1 expect_out(1'b0, "R2 idle at end");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule